// File: doc/BRIEF.md
# Oversampling Deskew Phase Selector

This block sits in front of a serial-to-parallel receiver. It removes a fixed skew between one data lane and the clock forwarded with it. Upstream logic samples the lane with several phases spaced across one bit period, and hands the block one sample per phase on every core clock. Each core clock carries one bit. While the deskew request is held high, the far end sends a repeating training word. The block scores every phase against that word and chooses one phase. From then on, the chosen phase's samples are forwarded to the deserializer.

Each phase has its own run counter. The counter counts consecutive training words that the phase captured with no bit error. A phase qualifies once its count reaches a parameterised threshold. At each word boundary the block checks whether any phase has qualified. If one has, it takes the centre of the longest group of adjacent qualifying phases and raises the lock flag. If a calibration timeout expires with no phase qualified, it raises an error flag and keeps the earlier selection. The selection can only change while the deskew request is high, so the forwarded data stream has no glitch in normal operation.

Top module: `oversample_deskew`

## Requirements
- R1: After reset, `locked`, `cal_err` and `bit_vld` are low, and the selected phase is phase 0.
- R2: `bit_vld` is high in the cycle after `deskew_req` is sampled low and low in the cycle after it is sampled high. `bit_out` is the selected phase's bit of `phase_smp`, registered once, so it appears one cycle after the sample is presented.
- R3: `deskew_req` sampled high while the block is idle starts a calibration and clears `locked` and `cal_err` at that same edge. The training word (`TRAIN_PAT`, TRAIN_W bits, default 8'hB4) is expected MSB first. Its first bit is expected in the cycle after the starting edge.
- R4: A phase qualifies after QUAL_WORDS (default 16) consecutive training words received with every bit matching. When at least one phase qualifies, `locked` rises one cycle after the edge that completes that word. With defaults this is QUAL_WORDS×TRAIN_W+1 edges after the starting edge.
- R5: The selected phase is the centre of the longest run of adjacent qualifying phase indices. For an even-length run it is the lower of the two middle indices. Among runs of equal length, the run with the lowest start index wins.
- R6: A single wrong bit in a word resets that phase's consecutive-word count to zero.
- R7: If TIMEOUT_WORDS (default 40) words complete with no qualifying phase, `cal_err` rises one cycle after the last of those words. `locked` stays low and the previous selection is kept.
- R8: The selected phase never changes while `deskew_req` is low. Dropping `deskew_req` before a decision ends the calibration without lock, without error and with the previous selection.
- R9: `locked` and `cal_err` are never high together.
- R10: `locked` and `cal_err` hold their value through normal operation until the next calibration starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one bit period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_smp | input | NPH | One captured bit per sampling phase, index 0 earliest |
| deskew_req | input | 1 | High to run calibration against the training word |
| bit_out | output | 1 | Bit forwarded from the selected phase |
| bit_vld | output | 1 | `bit_out` is normal-mode data |
| locked | output | 1 | Last calibration found a qualifying phase |
| cal_err | output | 1 | Last calibration timed out with no qualifying phase |

## Verification
The block's results fall due at different delays:
- `bit_out` and `bit_vld` follow their inputs after one edge.
- `locked` rises exactly one edge after the word-ending edge of the QUAL_WORDS-th clean word.
- `cal_err` rises one edge after the TIMEOUT_WORDS-th word.

The bench drives inputs on falling edges and counts the edges it has fed. It samples each flag on the falling edge just before its due cycle and again just after it, so both an early and a late flag are caught. The selected phase is read back in normal mode by making only one phase's sample high at a time.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

   typedef enum logic [1:0] {
      DSK_IDLE = 2'd0,
      DSK_CAL  = 2'd1,
      DSK_DONE = 2'd2
   } dsk_state_e;

   // Lower middle index of a run of adjacent phases
   function automatic int run_mid(input int start_idx, input int run_len);
      return start_idx + ((run_len > 0) ? (run_len - 1) / 2 : 0);
   endfunction

endpackage

// File: rtl/dsk_phase_scorer.sv
module dsk_phase_scorer #(
   parameter int QUAL_WORDS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   input  logic word_end,
   input  logic smp,
   input  logic exp_bit,
   output logic qual
);
   localparam int CW = $clog2(QUAL_WORDS + 1);

   logic          werr_q;
   logic [CW-1:0] cnt_q;
   logic          miss;

   assign miss = (smp != exp_bit);
   assign qual = (cnt_q == CW'(QUAL_WORDS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         werr_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         werr_q <= 1'b0;
         cnt_q  <= '0;
      end else if (active) begin
         if (word_end) begin
            werr_q <= 1'b0;
            if (werr_q || miss)
               cnt_q <= '0;
            else if (!qual)
               cnt_q <= cnt_q + CW'(1);
         end else begin
            werr_q <= werr_q | miss;
         end
      end
   end

   AST_QUAL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual) |-> $past(active && word_end)) else $error("qual rose mid-word"); // R4

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(QUAL_WORDS)) else $error("run counter overflow"); // R6

endmodule

// File: rtl/dsk_phase_picker.sv
module dsk_phase_picker
   import deskew_pkg::*;
#(
   parameter int NPH = 4,
   localparam int PW = (NPH > 1) ? $clog2(NPH) : 1
) (
   input  logic [NPH-1:0] qual,
   output logic           any_qual,
   output logic [PW-1:0]  pick
);
   int best_len;
   int best_st;
   int cur_len;
   int cur_st;

   always_comb begin
      best_len = 0;
      best_st  = 0;
      cur_len  = 0;
      cur_st   = 0;
      for (int p = 0; p < NPH; p++) begin
         if (qual[p]) begin
            if (cur_len == 0) cur_st = p;
            cur_len = cur_len + 1;
            // strict compare keeps the lower-indexed run on a tie
            if (cur_len > best_len) begin
               best_len = cur_len;
               best_st  = cur_st;
            end
         end else begin
            cur_len = 0;
         end
      end
      pick     = PW'(run_mid(best_st, best_len));
      any_qual = |qual;
   end

endmodule

// File: rtl/dsk_ctrl.sv
module dsk_ctrl
   import deskew_pkg::*;
#(
   parameter int                NPH           = 4,
   parameter int                TRAIN_W       = 8,
   parameter logic [TRAIN_W-1:0] TRAIN_PAT    = 8'hB4,
   parameter int                TIMEOUT_WORDS = 40,
   localparam int               PW = (NPH > 1) ? $clog2(NPH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          deskew_req,
   input  logic          any_qual,
   input  logic [PW-1:0] pick,
   output logic          start,
   output logic          active,
   output logic          word_end,
   output logic          exp_bit,
   output logic [PW-1:0] sel,
   output logic          locked,
   output logic          cal_err
);
   localparam int BW = (TRAIN_W > 1) ? $clog2(TRAIN_W) : 1;
   localparam int TW = $clog2(TIMEOUT_WORDS + 1);

   dsk_state_e    state_q;
   logic [BW-1:0] bidx_q;
   logic [TW-1:0] words_q;
   logic          chk_q;

   assign start    = (state_q == DSK_IDLE) && deskew_req;
   assign active   = (state_q == DSK_CAL) && deskew_req;
   assign word_end = active && (bidx_q == BW'(TRAIN_W - 1));
   assign exp_bit  = TRAIN_PAT[BW'(TRAIN_W - 1) - bidx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DSK_IDLE;
         bidx_q  <= '0;
         words_q <= '0;
         chk_q   <= 1'b0;
         sel     <= '0;
         locked  <= 1'b0;
         cal_err <= 1'b0;
      end else begin
         unique case (state_q)
            DSK_IDLE: begin
               if (deskew_req) begin
                  state_q <= DSK_CAL;
                  bidx_q  <= '0;
                  words_q <= '0;
                  chk_q   <= 1'b0;
                  locked  <= 1'b0;
                  cal_err <= 1'b0;
               end
            end
            DSK_CAL: begin
               if (!deskew_req) begin
                  state_q <= DSK_IDLE;
               end else begin
                  chk_q <= word_end;
                  if (word_end) begin
                     bidx_q <= '0;
                     if (words_q != TW'(TIMEOUT_WORDS))
                        words_q <= words_q + TW'(1);
                  end else begin
                     bidx_q <= bidx_q + BW'(1);
                  end
                  if (chk_q) begin
                     if (any_qual) begin
                        sel     <= pick;
                        locked  <= 1'b1;
                        state_q <= DSK_DONE;
                     end else if (words_q >= TW'(TIMEOUT_WORDS)) begin
                        cal_err <= 1'b1;
                        state_q <= DSK_DONE;
                     end
                  end
               end
            end
            DSK_DONE: begin
               if (!deskew_req) state_q <= DSK_IDLE;
            end
            default: state_q <= DSK_IDLE;
         endcase
      end
   end

   AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !deskew_req |=> $stable(sel)) else $error("selection moved in normal mode"); // R8

   AST_LOCK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(locked && cal_err)) else $error("lock and error together"); // R9

   AST_LOCK_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(any_qual)) else $error("lock without qualified phase"); // R4

   AST_ERR_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_err) |-> $stable(sel)) else $error("selection changed on timeout"); // R7

endmodule

// File: rtl/oversample_deskew.sv
module oversample_deskew #(
   parameter int                 NPH           = 4,
   parameter int                 TRAIN_W       = 8,
   parameter logic [TRAIN_W-1:0] TRAIN_PAT     = 8'hB4,
   parameter int                 QUAL_WORDS    = 16,
   parameter int                 TIMEOUT_WORDS = 40
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NPH-1:0] phase_smp,
   input  logic           deskew_req,
   output logic           bit_out,
   output logic           bit_vld,
   output logic           locked,
   output logic           cal_err
);
   localparam int PW = (NPH > 1) ? $clog2(NPH) : 1;

   generate
      if (NPH < 2) begin : g_chk_nph
         $error("NPH must be at least 2");
      end
      if (TRAIN_W < 2) begin : g_chk_w
         $error("TRAIN_W must be at least 2");
      end
      if (QUAL_WORDS < 1 || TIMEOUT_WORDS < QUAL_WORDS) begin : g_chk_win
         $error("need 1 <= QUAL_WORDS <= TIMEOUT_WORDS");
      end
   endgenerate

   logic           start;
   logic           active;
   logic           word_end;
   logic           exp_bit;
   logic [NPH-1:0] qual;
   logic           any_qual;
   logic [PW-1:0]  pick;
   logic [PW-1:0]  sel;

   generate
      for (genvar g = 0; g < NPH; g++) begin : g_score
         dsk_phase_scorer #(.QUAL_WORDS(QUAL_WORDS)) u_score (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start),
            .active  (active),
            .word_end(word_end),
            .smp     (phase_smp[g]),
            .exp_bit (exp_bit),
            .qual    (qual[g])
         );
      end
   endgenerate

   dsk_phase_picker #(.NPH(NPH)) u_pick (
      .qual    (qual),
      .any_qual(any_qual),
      .pick    (pick)
   );

   dsk_ctrl #(
      .NPH          (NPH),
      .TRAIN_W      (TRAIN_W),
      .TRAIN_PAT    (TRAIN_PAT),
      .TIMEOUT_WORDS(TIMEOUT_WORDS)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .deskew_req(deskew_req),
      .any_qual  (any_qual),
      .pick      (pick),
      .start     (start),
      .active    (active),
      .word_end  (word_end),
      .exp_bit   (exp_bit),
      .sel       (sel),
      .locked    (locked),
      .cal_err   (cal_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_out <= 1'b0;
         bit_vld <= 1'b0;
      end else begin
         bit_out <= phase_smp[sel];
         bit_vld <= !deskew_req;
      end
   end

   AST_VLD_OFF_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
      deskew_req |=> !bit_vld) else $error("valid during calibration"); // R2

endmodule

// File: tb/oversample_deskew_bench.sv
`timescale 1ns/1ps
module oversample_deskew_bench;
   localparam int         NPH  = 4;
   localparam int         W    = 8;
   localparam logic [7:0] PAT  = 8'hB4;
   localparam int         QW   = 16;
   localparam int         TOW  = 40;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NPH-1:0] phase_smp = '0;
   logic           deskew_req = 1'b0;
   logic           bit_out, bit_vld, locked, cal_err;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   oversample_deskew #(.NPH(NPH), .TRAIN_W(W), .TRAIN_PAT(PAT),
                       .QUAL_WORDS(QW), .TIMEOUT_WORDS(TOW)) u_oversample_deskew (
      .clk(clk), .rst_n(rst_n), .phase_smp(phase_smp), .deskew_req(deskew_req),
      .bit_out(bit_out), .bit_vld(bit_vld), .locked(locked), .cal_err(cal_err));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic put_bit(input int k, input logic [NPH-1:0] good, input int bad_ph);
      logic b;
      b = PAT[W - 1 - (k % W)];
      for (int p = 0; p < NPH; p++)
         phase_smp[p] = good[p] ? b : ~b;
      if (bad_ph >= 0) phase_smp[bad_ph] = ~phase_smp[bad_ph];
   endtask

   // start calibration, check R3 clearing
   task automatic start_cal();
      deskew_req = 1'b1;
      @(negedge clk);
      check(bit_vld == 1'b0, "R2", "bit_vld in cal", bit_vld, 0);
      check(locked == 1'b0,  "R3", "locked cleared", locked, 0);
      check(cal_err == 1'b0, "R3", "cal_err cleared", cal_err, 0);
   endtask

   task automatic feed(input logic [NPH-1:0] good, input int nbits,
                       input int bad_ph, input int bad_bit);
      for (int k = 0; k < nbits; k++) begin
         put_bit(k, good, (k == bad_bit) ? bad_ph : -1);
         @(negedge clk);
      end
   endtask

   // leave calibration and read the selection back through bit_out
   task automatic check_sel(input int exp, input string req);
      deskew_req = 1'b0;
      phase_smp = '0;
      @(negedge clk);
      check(bit_vld == 1'b1, "R2", "bit_vld normal", bit_vld, 1);
      for (int p = 0; p < NPH; p++) begin
         phase_smp = '0;
         phase_smp[p] = 1'b1;
         @(negedge clk);
         check(bit_out == (p == exp), req, $sformatf("bit_out phase %0d hot", p),
               bit_out, (p == exp));
      end
   endtask

   task automatic t_reset();
      check(locked == 1'b0,  "R1", "locked at reset", locked, 0);
      check(cal_err == 1'b0, "R1", "cal_err at reset", cal_err, 0);
      check(bit_vld == 1'b0, "R1", "bit_vld at reset", bit_vld, 0);
      check_sel(0, "R1");
   endtask

   task automatic t_cal(input logic [NPH-1:0] good, input int exp_sel,
                        input int bad_ph, input int bad_bit, input string req);
      start_cal();
      feed(good, QW * W, bad_ph, bad_bit);
      check(locked == 1'b0, "R4", "locked before due", locked, 0);
      put_bit(0, good, -1);
      @(negedge clk);
      check(locked == 1'b1,  "R4", "locked when due", locked, 1);
      check(cal_err == 1'b0, "R9", "cal_err with lock", cal_err, 0);
      check_sel(exp_sel, req);
      check(locked == 1'b1, "R10", "locked held in normal mode", locked, 1);
   endtask

   task automatic t_abort(input int keep_sel);
      start_cal();
      feed(4'b1000, 8 * W, -1, -1);
      check_sel(keep_sel, "R8");
      check(locked == 1'b0,  "R8", "locked after abort", locked, 0);
      check(cal_err == 1'b0, "R8", "cal_err after abort", cal_err, 0);
   endtask

   task automatic t_timeout(input int keep_sel);
      start_cal();
      feed('0, TOW * W, -1, -1);
      check(cal_err == 1'b0, "R7", "cal_err before due", cal_err, 0);
      put_bit(0, '0, -1);
      @(negedge clk);
      check(cal_err == 1'b1, "R7", "cal_err when due", cal_err, 1);
      check(locked == 1'b0,  "R7", "locked on timeout", locked, 0);
      check_sel(keep_sel, "R7");
      check(cal_err == 1'b1, "R10", "cal_err held", cal_err, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cal(4'b1110, 2, -1, -1, "R5");   // run 1..3, centre 2
      t_cal(4'b1001, 0, -1, -1, "R5");   // equal runs, lower wins
      t_cal(4'b0110, 1, -1, -1, "R5");   // even run, lower middle
      t_cal(4'b1000, 3, -1, -1, "R5");   // single phase
      t_cal(4'b1110, 1, 3, 5 * W + 3, "R6"); // phase 3 broken in word 5
      t_abort(1);
      t_timeout(1);
      t_cal(4'b1111, 1, -1, -1, "R3");   // fresh start after error
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, got 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule